// File: doc/BRIEF.md
# One-Shot Match-Compare Timer

This block is a memory-mapped timer for an operating system's timekeeping. It holds one counter and one match value. Writing a match value arms a one-shot count. The counter then moves up by one on every tick pulse, starting from wherever it stands. It wraps through zero when the target lies at or below the present count. When the counter lands on the target it halts there. If interrupts are enabled at that moment, a sticky status flag is set and a level interrupt is raised.

Software reaches the block over a plain 32-bit register bus: byte address, write strobe, write data and registered read data. Only full-word accesses at word-aligned addresses are decoded. The count rate comes from a one-cycle clock-enable input, so the bus clock can run faster than the count. At the intended rate, this input pulses at 50 MHz.

Top module: `ost_match_timer`

## Requirements
- R1: After reset the counter, status and enable registers read zero, `irq` is low and the timer is idle: tick pulses do not move the counter until a match value is written.
- R2: Once armed, the counter advances by exactly one on each cycle with `tick` high and holds on cycles with `tick` low.
- R3: When the counter becomes equal to the match value it stops there and stays put on later ticks until the match register is written again.
- R4: Counting is modulo 2^CNT_W. A match value below the present count is reached by wrapping through the all-ones value to zero. A match value equal to the present count takes a full 2^CNT_W ticks.
- R5: On reaching the match, status bit 0 is set and `irq` goes high only if the enable register held a nonzero value before that cycle; otherwise both stay low.
- R6: Writing a nonzero enable after a match has already happened leaves status and `irq` low.
- R7: Any write to byte address 0x14 clears status and lowers `irq` on the next cycle. A match that occurs on the same cycle as such a write takes precedence and leaves status set.
- R8: A write to byte address 0x00 (match register) in the same cycle as a match re-arms the timer with the new value: the counter holds its value that cycle and status is not set.
- R9: Reads return data one cycle after the address is presented: 0x10 gives the counter zero-extended, 0x14 gives status in bit 0, 0x1C gives the full enable word as written.
- R10: Every other address reads zero and ignores writes, including 0x00 on read and any address not a multiple of four.
- R11: Writing a new match value while a count is in progress replaces the target; counting carries on from the present counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt, high while status is set |

## Verification
The bench builds the timer with CNT_W = 8, keeping DATA_W = 32 and ADDR_W = 8. With this counter width, every distance from the present count to a new target, 1 through 256, can be swept in turn, including the full-wrap case where target equals count. That sweep compares the counter one tick before and at the match against modular arithmetic. The narrow counter also puts collisions of match writes, status clears and the match cycle, as well as the unmapped-address behaviour, within a few cycles of each other.

// File: rtl/ost_pkg.sv
package ost_pkg;
  // Byte offsets decoded by the register bus
  localparam logic [7:0] OFS_MATCH  = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h10;
  localparam logic [7:0] OFS_STATUS = 8'h14;
  localparam logic [7:0] OFS_ENABLE = 8'h1C;
endpackage

// File: rtl/ost_count.sv
module ost_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] arm_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, tgt_q, cnt_nx;
  logic             run_q;

  assign cnt_nx = cnt_q + CNT_W'(1);
  // a match write in the same cycle wins over the hit
  assign hit_o  = run_q & tick_i & ~arm_i & (cnt_nx == tgt_q);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tgt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      tgt_q <= arm_val_i;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_nx;
      if (cnt_nx == tgt_q) run_q <= 1'b0;
    end
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(cnt_q)); // R3
  AST_STOP_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> (cnt_q == tgt_q)); // R3
  AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/ost_event.sv
module ost_event #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic              en_we_i,
  input  logic [DATA_W-1:0] en_wdata_i,
  input  logic              st_we_i,
  output logic [DATA_W-1:0] en_o,
  output logic              st_o
);
  logic [DATA_W-1:0] en_q;
  logic              st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_wdata_i;
      if (hit_i && (en_q != '0)) st_q <= 1'b1;
      else if (st_we_i)          st_q <= 1'b0;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;

  AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q) |-> ($past(en_q) != '0)); // R5
  AST_STATUS_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q) |-> $past(hit_i)); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (st_we_i && !hit_i) |=> !st_q); // R7
endmodule

// File: rtl/ost_rdmux.sv
module ost_rdmux
  import ost_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              st_i,
  input  logic [DATA_W-1:0] en_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;
  logic              mapped;

  assign mapped = (addr_i == ADDR_W'(OFS_COUNT)) || (addr_i == ADDR_W'(OFS_STATUS)) ||
                  (addr_i == ADDR_W'(OFS_ENABLE));

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (addr_i == ADDR_W'(OFS_COUNT))  rdata_q <= DATA_W'(cnt_i);
    else if (addr_i == ADDR_W'(OFS_STATUS)) rdata_q <= DATA_W'(st_i);
    else if (addr_i == ADDR_W'(OFS_ENABLE)) rdata_q <= en_i;
    else rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rdata_q == '0)); // R10
endmodule

// File: rtl/ost_match_timer.sv
module ost_match_timer
  import ost_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             wr_match, wr_status, wr_enable, hit, st;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] en;

  assign wr_match  = bus_we && (bus_addr == ADDR_W'(OFS_MATCH));
  assign wr_status = bus_we && (bus_addr == ADDR_W'(OFS_STATUS));
  assign wr_enable = bus_we && (bus_addr == ADDR_W'(OFS_ENABLE));

  ost_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick), .arm_i(wr_match),
    .arm_val_i(bus_wdata[CNT_W-1:0]), .cnt_o(cnt), .hit_o(hit)
  );

  ost_event #(.DATA_W(DATA_W)) u_event (
    .clk(clk), .rst(rst), .hit_i(hit), .en_we_i(wr_enable),
    .en_wdata_i(bus_wdata), .st_we_i(wr_status), .en_o(en), .st_o(st)
  );

  ost_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .cnt_i(cnt), .st_i(st),
    .en_i(en), .rdata_o(bus_rdata)
  );

  assign irq = st;

  AST_ARM_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (wr_match && !st) |=> !irq); // R8
endmodule

// File: tb/ost_match_timer_tb.sv
module ost_match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int MOD    = 1 << CNT_W;

  localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h10, A_STAT = 8'h14, A_EN = 8'h1C;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_we = 1'b0, irq;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0, bus_rdata, rv;
  int errors = 0, checks = 0, c = 0;

  ost_match_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and idle
    rd(A_COUNT, rv); chk("R1 counter", rv, 0);
    rd(A_STAT, rv);  chk("R1 status", rv, 0);
    rd(A_EN, rv);    chk("R1 enable", rv, 0);
    chk("R1 irq", irq, 0);
    tick_n(5);
    rd(A_COUNT, rv); chk("R1 idle counter", rv, 0);

    // R9 enable readback, full word
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, rv); chk("R9 enable word", rv, 32'hA5A5_0000);

    // R2 step per tick only
    wr(A_MATCH, 10);
    tick_n(3);
    repeat (4) @(negedge clk);
    rd(A_COUNT, rv); chk("R2 three ticks", rv, 3);
    tick_n(7);
    rd(A_COUNT, rv); chk("R3 reach match", rv, 10);
    rd(A_STAT, rv);  chk("R5 status set", rv, 1);
    chk("R5 irq high", irq, 1);
    tick_n(5);
    rd(A_COUNT, rv); chk("R3 halted", rv, 10);
    wr(A_STAT, 0);
    rd(A_STAT, rv); chk("R7 status cleared", rv, 0);
    chk("R7 irq low", irq, 0);
    c = 10;

    // R4 sweep of every distance, including full wrap
    for (int d = 0; d < MOD; d++) begin
      int m, t;
      m = (c + d) % MOD;
      t = (d == 0) ? MOD : d;
      wr(A_MATCH, m);
      tick_n(t - 1);
      rd(A_COUNT, rv); chk("R4 before match", rv, (c + t - 1) % MOD);
      rd(A_STAT, rv);  chk("R4 no early status", rv, 0);
      tick_n(1);
      rd(A_COUNT, rv); chk("R4 at match", rv, m);
      chk("R4 irq at match", irq, 1);
      wr(A_STAT, 0);
      c = m;
    end

    // R5/R6 match with enable off, then enable afterwards
    wr(A_EN, 0);
    wr(A_MATCH, (c + 3) % MOD);
    tick_n(3);
    c = (c + 3) % MOD;
    rd(A_COUNT, rv); chk("R5 count reached", rv, c);
    rd(A_STAT, rv);  chk("R5 no status when disabled", rv, 0);
    wr(A_EN, 1);
    rd(A_STAT, rv);  chk("R6 late enable no status", rv, 0);
    chk("R6 irq stays low", irq, 0);

    // R11 re-arm while running
    wr(A_MATCH, (c + 20) % MOD);
    tick_n(5);
    wr(A_MATCH, (c + 8) % MOD);
    tick_n(2);
    rd(A_COUNT, rv); chk("R11 continues", rv, (c + 7) % MOD);
    rd(A_STAT, rv);  chk("R11 not yet", rv, 0);
    tick_n(1);
    rd(A_STAT, rv);  chk("R11 new target hit", rv, 1);
    c = (c + 8) % MOD;
    wr(A_STAT, 0);

    // R8 match write colliding with the hit
    wr(A_MATCH, (c + 2) % MOD);
    tick_n(1);
    @(negedge clk); tick = 1'b1; bus_we = 1'b1; bus_addr = A_MATCH; bus_wdata = (c + 5) % MOD;
    @(negedge clk); tick = 1'b0; bus_we = 1'b0;
    chk("R8 no status on collision", irq, 0);
    rd(A_COUNT, rv); chk("R8 counter held", rv, (c + 1) % MOD);
    tick_n(3);
    rd(A_STAT, rv); chk("R8 still armed", rv, 0);
    tick_n(1);
    rd(A_COUNT, rv); chk("R8 new match", rv, (c + 5) % MOD);
    chk("R8 irq at new match", irq, 1);
    c = (c + 5) % MOD;
    wr(A_STAT, 0);

    // R7 hit wins over clear in the same cycle
    wr(A_MATCH, (c + 1) % MOD);
    @(negedge clk); tick = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 0;
    @(negedge clk); tick = 1'b0; bus_we = 1'b0;
    rd(A_STAT, rv); chk("R7 hit beats clear", rv, 1);
    c = (c + 1) % MOD;
    wr(A_STAT, 0);

    // R10 unmapped and misaligned
    rd(A_MATCH, rv); chk("R10 match reads zero", rv, 0);
    rd(8'h04, rv);   chk("R10 0x04 reads zero", rv, 0);
    rd(8'h1D, rv);   chk("R10 misaligned reads zero", rv, 0);
    wr(8'h1D, 0);
    rd(A_EN, rv);    chk("R10 misaligned enable write ignored", rv, 1);
    wr(8'h01, (c + 1) % MOD);
    tick_n(2);
    rd(A_COUNT, rv); chk("R10 misaligned match write ignored", rv, c);
    wr(8'h15, 0);
    wr(A_MATCH, (c + 1) % MOD);
    tick_n(1);
    wr(8'h15, 0);
    rd(A_STAT, rv);  chk("R10 misaligned status write ignored", rv, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule